// File: doc/BRIEF.md
# PLL Lock Detector with Feedback Watchdog

This block watches the reference clock and the feedback clock of a phase-locked loop and drives a single lock indicator. Both clocks are brought into a fast sampling clock domain. There, the gap between each feedback rising edge and the nearest reference rising edge is measured in sampling-clock ticks. Each feedback cycle gets exactly one verdict, either on time or phase error. It makes no difference which edge comes first.

A hysteresis state machine turns the stream of verdicts into the lock flag. The thresholds are asymmetric. An unlocked loop must show a long unbroken run of on-time cycles before lock is claimed. A locked loop gives up lock after a short unbroken run of errored cycles. A watchdog catches a feedback clock that has stopped. It counts reference edges through a prescaler, restarts on every feedback edge, and removes lock when its limit is reached. The lock output has no enable, so it is always actively driven.

All edges pass through synchronizers of equal depth. Measured separations are therefore relative, and fixed latency cancels out.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `rst_n` is low, and immediately after it rises, `lock_o` is 0. Both the error run and the good run start at zero, so exactly GOOD_LIMIT on-time cycles are needed for the first lock.
- R2: A feedback cycle is on time when its synchronized rising edge lies within PHASE_TOL sample ticks of a synchronized reference rising edge, either before it or after it. A separation of PHASE_TOL ticks counts as on time. PHASE_TOL+1 ticks or more counts as a phase error.
- R3: While unlocked, `lock_o` rises after GOOD_LIMIT consecutive on-time feedback cycles, and not after GOOD_LIMIT-1.
- R4: While unlocked, any errored feedback cycle restarts the on-time run from zero.
- R5: While locked, `lock_o` falls after BAD_LIMIT consecutive errored feedback cycles, and not after BAD_LIMIT-1.
- R6: While locked, any on-time feedback cycle restarts the error run from zero.
- R7: While locked, if WD_DIV*WD_LIMIT reference rising edges arrive with no feedback rising edge in between, `lock_o` falls. One fewer reference edge leaves it high.
- R8: Every feedback rising edge restarts the watchdog, including its prescaler.
- R9: `lock_o` is a plain two-state output with no enable. It is never X or Z after reset. 1 means locked and 0 means unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| fb_clk_i | input | 1 | Feedback clock, asynchronous to `clk` |
| lock_o | output | 1 | Lock indicator, 1 = locked |

## Verification
The bench builds the block with PHASE_TOL = 3, BAD_LIMIT = 4, GOOD_LIMIT = 32, WD_DIV = 4 and WD_LIMIT = 8. With a 16-tick reference period, offsets of ±3 and ±4 sit exactly on either side of the tolerance, in both edge orders. The small watchdog makes the 32-edge timeout reachable in a few hundred cycles. That lets the bench exercise the off-by-one boundary of that timeout. It also tests a restart of the timeout partway through.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  typedef struct packed {
    logic valid;
    logic err;
  } verdict_t;

endpackage

// File: rtl/lkd_edge_sync.sv
module lkd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] shift_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      last_q  <= 1'b0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], async_i};
      last_q  <= shift_q[STAGES-1];
    end
  end

  assign rise_o = shift_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lkd_phase_window.sv
module lkd_phase_window
  import lkd_pkg::*;
#(
  parameter int PHASE_TOL = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_rise,
  input  logic     fb_rise,
  output verdict_t verdict_o
);

  localparam int CW = $clog2(PHASE_TOL + 2);
  localparam logic [CW-1:0] SAT_V  = CW'(PHASE_TOL + 1);
  localparam logic [CW-1:0] TOL_V  = CW'(PHASE_TOL);
  localparam logic [CW-1:0] LAST_V = CW'(PHASE_TOL - 1);

  // ticks since the last reference edge, saturating beyond the tolerance
  logic [CW-1:0] since_ref_q;
  // feedback led: waiting for a reference edge inside the window
  logic          pend_q, pend_d;
  logic [CW-1:0] win_q, win_d;
  verdict_t      v_d;

  always_comb begin
    v_d    = '0;
    pend_d = pend_q;
    win_d  = win_q;
    if (pend_q) begin
      if (ref_rise) begin
        v_d    = '{valid: 1'b1, err: 1'b0};
        pend_d = 1'b0;
      end else if (fb_rise || win_q == LAST_V) begin
        v_d    = '{valid: 1'b1, err: 1'b1};
        pend_d = 1'b0;
      end else begin
        win_d = win_q + 1'b1;
      end
    end
    if (fb_rise && !(pend_q && ref_rise)) begin
      if (ref_rise || since_ref_q < TOL_V) begin
        if (!v_d.valid) v_d = '{valid: 1'b1, err: 1'b0};
      end else begin
        pend_d = 1'b1;
        win_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ref_q <= SAT_V;
      pend_q      <= 1'b0;
      win_q       <= '0;
      verdict_o   <= '0;
    end else begin
      if (ref_rise)                 since_ref_q <= '0;
      else if (since_ref_q != SAT_V) since_ref_q <= since_ref_q + 1'b1;
      pend_q    <= pend_d;
      win_q     <= win_d;
      verdict_o <= v_d;
    end
  end

endmodule

// File: rtl/lkd_watchdog.sv
module lkd_watchdog #(
  parameter int WD_DIV   = 16,
  parameter int WD_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic expired_o
);

  localparam int PW = (WD_DIV > 1) ? $clog2(WD_DIV) : 1;
  localparam int TW = $clog2(WD_LIMIT + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(WD_DIV - 1);
  localparam logic [TW-1:0] TMR_END  = TW'(WD_LIMIT);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else if (fb_rise) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else if (ref_rise) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (tmr_q != TMR_END) tmr_q <= tmr_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expired_o = (tmr_q == TMR_END);

endmodule

// File: rtl/lkd_hysteresis.sv
module lkd_hysteresis
  import lkd_pkg::*;
#(
  parameter int BAD_LIMIT  = 4,
  parameter int GOOD_LIMIT = 32,
  parameter int BW = $clog2(BAD_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  verdict_t      verdict_i,
  input  logic          wd_expired,
  output logic          lock_o,
  output logic [BW-1:0] bad_cnt_o
);

  localparam int GW = $clog2(GOOD_LIMIT + 1);
  localparam logic [BW-1:0] BAD_LAST  = BW'(BAD_LIMIT - 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_LIMIT - 1);

  logic [GW-1:0] good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o    <= 1'b0;
      bad_cnt_o <= '0;
      good_q    <= '0;
    end else if (lock_o && wd_expired) begin
      lock_o    <= 1'b0;
      bad_cnt_o <= '0;
      good_q    <= '0;
    end else if (verdict_i.valid) begin
      if (verdict_i.err) begin
        good_q <= '0;
        if (lock_o) begin
          if (bad_cnt_o == BAD_LAST) begin
            lock_o    <= 1'b0;
            bad_cnt_o <= '0;
          end else begin
            bad_cnt_o <= bad_cnt_o + 1'b1;
          end
        end
      end else begin
        bad_cnt_o <= '0;
        if (!lock_o) begin
          if (good_q == GOOD_LAST) begin
            lock_o <= 1'b1;
            good_q <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import lkd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PHASE_TOL   = 4,
  parameter int BAD_LIMIT   = 4,
  parameter int GOOD_LIMIT  = 32,
  parameter int WD_DIV      = 16,
  parameter int WD_LIMIT    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk_i,
  input  logic fb_clk_i,
  output logic lock_o
);

  localparam int NUM_IN = 2;
  localparam int BAD_W  = $clog2(BAD_LIMIT + 1);

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] rise;
  logic              ref_rise;
  logic              fb_rise;
  verdict_t          verdict;
  logic              v_valid;
  logic              v_err;
  logic              wd_expired;
  logic [BAD_W-1:0]  bad_cnt;

  assign raw_in = {fb_clk_i, ref_clk_i};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    lkd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(raw_in[i]),
      .rise_o (rise[i])
    );
  end

  assign ref_rise = rise[0];
  assign fb_rise  = rise[1];

  lkd_phase_window #(.PHASE_TOL(PHASE_TOL)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .verdict_o(verdict)
  );

  assign v_valid = verdict.valid;
  assign v_err   = verdict.err;

  lkd_watchdog #(.WD_DIV(WD_DIV), .WD_LIMIT(WD_LIMIT)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .expired_o(wd_expired)
  );

  lkd_hysteresis #(
    .BAD_LIMIT (BAD_LIMIT),
    .GOOD_LIMIT(GOOD_LIMIT),
    .BW        (BAD_W)
  ) u_hyst (
    .clk       (clk),
    .rst_n     (rst_n),
    .verdict_i (verdict),
    .wd_expired(wd_expired),
    .lock_o    (lock_o),
    .bad_cnt_o (bad_cnt)
  );

endmodule

// File: rtl/lkd_lock_checker.sv
module lkd_lock_checker #(
  parameter int BAD_LIMIT = 4,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock_o,
  input logic          v_valid,
  input logic          v_err,
  input logic          wd_expired,
  input logic          fb_rise,
  input logic [BW-1:0] bad_cnt
);

  always @(posedge clk) begin
    if (!rst_n) p_reset_unlocked_r1: assert (!lock_o);
  end

  p_rise_needs_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(v_valid && !v_err));

  p_fall_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(wd_expired || (v_valid && v_err)));

  p_bad_run_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt < BW'(BAD_LIMIT));

  p_unlocked_no_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> bad_cnt == '0);

  p_fb_clears_wd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rise |=> !wd_expired);

  p_known_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(lock_o));

endmodule

bind pll_lock_monitor lkd_lock_checker #(.BAD_LIMIT(BAD_LIMIT), .BW(BAD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lock_o    (lock_o),
  .v_valid   (v_valid),
  .v_err     (v_err),
  .wd_expired(wd_expired),
  .fb_rise   (fb_rise),
  .bad_cnt   (bad_cnt)
);

// File: tb/tb_pll_lock_monitor.sv
module tb_pll_lock_monitor;

  localparam int TOL   = 3;
  localparam int BADL  = 4;
  localparam int GOODL = 32;
  localparam int DIV   = 4;
  localparam int LIM   = 8;
  localparam int PER   = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_clk_i;
  logic fb_clk_i;
  logic lock_o;

  always #10 clk = ~clk;

  pll_lock_monitor #(
    .SYNC_STAGES(2), .PHASE_TOL(TOL), .BAD_LIMIT(BADL),
    .GOOD_LIMIT(GOODL), .WD_DIV(DIV), .WD_LIMIT(LIM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk_i),
    .fb_clk_i(fb_clk_i), .lock_o(lock_o)
  );

  typedef struct {
    bit    exp_lock;
    string tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // reference model state
  bit m_lock = 0;
  int m_good = 0;
  int m_bad  = 0;
  int m_wd   = 0;

  task automatic compare(input bit exp, input string tag);
    n_cmp++;
    if ($isunknown(lock_o)) begin
      n_bad++;
      $display("FAIL %s (R9): lock_o=%b expected known %0d", tag, lock_o, exp);
    end else if (lock_o !== exp) begin
      n_bad++;
      $display("FAIL %s: lock_o=%0d expected %0d", tag, lock_o, exp);
    end
  endtask

  // monitor: pops one expectation per check event
  initial begin
    forever begin
      @(chk_ev);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        compare(it.exp_lock, it.tag);
      end
    end
  end

  function automatic void model(input bit fb_on, input int off);
    if (fb_on) begin
      bit err;
      m_wd = 0;
      err  = (off > TOL) || (-off > TOL);
      if (err) begin
        m_good = 0;
        if (m_lock) begin
          m_bad++;
          if (m_bad == BADL) begin m_lock = 0; m_bad = 0; end
        end
      end else begin
        m_bad = 0;
        if (!m_lock) begin
          m_good++;
          if (m_good == GOODL) begin m_lock = 1; m_good = 0; end
        end
      end
    end else begin
      m_wd++;
      if (m_lock && m_wd >= DIV * LIM) begin
        m_lock = 0; m_good = 0; m_bad = 0;
      end
    end
  endfunction

  // driver: one reference period; ref rises at tick 8, feedback at 8+off
  task automatic run_period(input bit fb_on, input int off, input bit rec,
                            input string tag);
    for (int t = 0; t < PER; t++) begin
      @(negedge clk);
      ref_clk_i = (t >= 8);
      fb_clk_i  = fb_on && (t >= 8 + off);
      if (t == 6) -> chk_ev;
    end
    if (rec) begin
      item_t it;
      model(fb_on, off);
      it.exp_lock = m_lock;
      it.tag      = tag;
      q.push_back(it);
    end
  endtask

  initial begin
    int wdog = 0;
    while (!done) begin
      @(posedge clk);
      wdog++;
      if (wdog > 20000) begin
        n_bad++;
        $display("FAIL watchdog: run hung, cycles=%0d expected <= 20000", wdog);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    ref_clk_i = 1'b0;
    fb_clk_i  = 1'b0;
    repeat (4) @(negedge clk);
    compare(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare(1'b0, "R1 after reset");

    // unlocked: on-time runs with boundary offsets, one error restarts the run
    for (int i = 0; i < 20; i++) begin
      int offs[3] = '{0, 3, -3};
      run_period(1, offs[i % 3], 1, "R2/R1 good run");
    end
    run_period(1, 4, 1, "R2 error at tol+1");
    for (int i = 0; i < GOODL - 1; i++) begin
      int offs[4] = '{2, -3, 3, -1};
      run_period(1, offs[i % 4], 1, "R4 run restarted, R3 not yet");
    end
    run_period(1, 0, 1, "R3 lock after full run");

    // locked: error runs below limit, clearing, then drop
    run_period(1, 5, 1, "R5 err1");
    run_period(1, -4, 1, "R2 R5 err2 lead");
    run_period(1, 4, 1, "R5 err3 still locked");
    run_period(1, -3, 1, "R6 good clears error run");
    run_period(1, -6, 1, "R6 err1");
    run_period(1, 6, 1, "R6 err2");
    run_period(1, 4, 1, "R6 err3 still locked");
    run_period(1, -5, 1, "R5 fourth error drops lock");

    // relock, then watchdog
    for (int i = 0; i < GOODL; i++) run_period(1, 1, 1, "R3 relock");
    for (int i = 0; i < 20; i++) run_period(0, 0, 1, "R8 feedback gap");
    run_period(1, 1, 1, "R8 feedback edge restarts watchdog");
    for (int i = 0; i < DIV * LIM - 1; i++) run_period(0, 0, 1, "R7 below timeout");
    run_period(0, 0, 1, "R7 timeout drops lock");
    run_period(0, 0, 1, "R7 stays unlocked");
    run_period(1, 0, 1, "R4 after watchdog drop");
    run_period(1, 0, 0, "flush");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule